// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block watches the first six bytes of each incoming frame, which carry the destination MAC address, and decides whether the frame should be kept or dropped. Bytes arrive one per clock on a byte stream with a valid strobe and a start-of-frame marker. Each address byte is compared against a programmed station address as it arrives. An all-ones check and a CRC-32 over the address are updated in the same pass. One cycle after the sixth byte, a single-cycle decision pulse carries the verdict and a flag that marks a group (multicast or broadcast) destination.

Filtering is set by a small byte-wide register space. It holds the station address, a 64-bit multicast hash table and a mode register with three enables: accept everything, accept broadcast, and accept hashed multicast. Writes land in a shadow copy at once. They reach the copy used for filtering only while no address is being examined, so a frame is always judged against one consistent setting. Frame storage and the whole-frame CRC check are handled elsewhere.

Top module: `dest_addr_filter`

## Requirements
- R1: When mode register bit 4 is set, every frame is accepted whatever its destination.
- R2: A destination of six 0xFF bytes is broadcast. It is accepted only when mode bit 2 is set, even if mode bit 3 is set and its hash bit is set. This holds unless R1 applies.
- R3: Any other destination whose first byte has bit 0 set is multicast. It is accepted only when mode bit 3 is set and the hash table bit chosen by R4 is 1.
- R4: The hash index is bits 31..26 of a CRC-32 over the six destination bytes. The CRC starts at all ones, uses polynomial 0x04C11DB7, and shifts left. Each byte enters least significant bit first, and there is no final inversion. Index bits 5..3 pick the hash byte and bits 2..0 pick the bit within it.
- R5: A destination whose first byte has bit 0 clear is accepted only when all six bytes equal the station address bytes in order. Station register 0 is compared with the first byte.
- R6: `dec_valid` pulses for exactly one cycle, in the cycle after the sixth address byte is taken. `dec_group` then equals bit 0 of the first byte. Bytes after the sixth are ignored until the next `rx_sof`. An `rx_sof` before six bytes restarts the address.
- R7: A rejected frame produces `dec_valid` with `dec_accept` low and nothing else. `dec_accept` and `dec_group` are low whenever `dec_valid` is low.
- R8: Register map on `cfg_addr`: 0..5 hold station bytes, 6..13 hold hash bytes 0..7, and 15 holds the mode register. A write takes effect for frames whose first byte arrives at least one cycle later. A write in the same cycle as a first byte, or during the address bytes, takes effect from the next frame.
- R9: After reset, all outputs are low and all registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register address |
| cfg_wdata | input | 8 | Register write data |
| rx_valid | input | 1 | Frame byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_data | input | 8 | Frame byte |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted (with dec_valid) |
| dec_group | output | 1 | Group destination (with dec_valid) |

## Verification
A register write and the first address byte of a frame can fall in the same cycle. The bench provokes this by driving a station-byte write together with `rx_sof` for a frame aimed at the old station address. It judges the result by requiring that frame to be accepted under the old value and the next identical frame to be rejected under the new one. The same check is repeated with the write placed in the middle of the address bytes. A bound check also requires the filtering copy to hold still for the whole address phase.

// File: rtl/filt_pkg.sv
package filt_pkg;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
  // packed mode flags held by the filter
  localparam int MB_BC  = 0;  // written from data bit 2
  localparam int MB_MC  = 1;  // written from data bit 3
  localparam int MB_ALL = 2;  // written from data bit 4

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/filt_cfg.sv
module filt_cfg #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BYTES = 8,
  parameter int CFG_AW     = 4,
  parameter int MODE_ADDR  = 15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [CFG_AW-1:0]       cfg_addr,
  input  logic [7:0]              cfg_wdata,
  input  logic                    freeze,
  output logic [ADDR_BYTES*8-1:0] act_sta,
  output logic [HASH_BYTES*8-1:0] act_hash,
  output logic [2:0]              act_mode
);
  localparam int STA_W  = ADDR_BYTES * 8;
  localparam int HASH_W = HASH_BYTES * 8;

  logic [STA_W-1:0]  sta_q, sta_n;
  logic [HASH_W-1:0] hash_q, hash_n;
  logic [2:0]        mode_q, mode_n;

  always_comb begin
    sta_n  = sta_q;
    hash_n = hash_q;
    mode_n = mode_q;
    if (cfg_we) begin
      for (int k = 0; k < ADDR_BYTES; k++)
        if (cfg_addr == CFG_AW'(k)) sta_n[8*k +: 8] = cfg_wdata;
      for (int k = 0; k < HASH_BYTES; k++)
        if (cfg_addr == CFG_AW'(ADDR_BYTES + k)) hash_n[8*k +: 8] = cfg_wdata;
      if (cfg_addr == CFG_AW'(MODE_ADDR))
        mode_n = {cfg_wdata[4], cfg_wdata[3], cfg_wdata[2]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sta_q    <= '0;
      hash_q   <= '0;
      mode_q   <= '0;
      act_sta  <= '0;
      act_hash <= '0;
      act_mode <= '0;
    end else begin
      sta_q  <= sta_n;
      hash_q <= hash_n;
      mode_q <= mode_n;
      if (!freeze) begin
        act_sta  <= sta_n;
        act_hash <= hash_n;
        act_mode <= mode_n;
      end
    end
  end
endmodule

// File: rtl/filt_crc.sv
module filt_crc #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             first,
  input  logic [7:0]       data,
  output logic [IDX_W-1:0] hash_idx
);
  import filt_pkg::*;

  logic [31:0] crc_q, crc_nxt;

  assign crc_nxt  = crc_byte(first ? CRC_SEED : crc_q, data);
  assign hash_idx = crc_nxt[31 -: IDX_W];

  always_ff @(posedge clk) begin
    if (rst)       crc_q <= CRC_SEED;
    else if (take) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/filt_match.sv
module filt_match #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BYTES = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                rx_valid,
  input  logic                                rx_sof,
  input  logic [7:0]                          rx_data,
  input  logic [ADDR_BYTES*8-1:0]             act_sta,
  input  logic [HASH_BYTES*8-1:0]             act_hash,
  input  logic [2:0]                          act_mode,
  input  logic [$clog2(HASH_BYTES*8)-1:0]     hash_idx,
  output logic                                take,
  output logic                                first,
  output logic                                freeze,
  output logic                                dec_valid,
  output logic                                dec_accept,
  output logic                                dec_group
);
  import filt_pkg::*;
  localparam int POS_W = $clog2(ADDR_BYTES + 1);

  logic [POS_W-1:0] pos_q, cur;
  logic             last;
  logic [7:0]       sta_b;
  logic             uc_q, bc_q, grp_q;
  logic             uc_n, bc_n, grp_n, hit, acc_n;

  assign first  = rx_valid && rx_sof;
  assign take   = first || (rx_valid && pos_q != '0);
  assign cur    = rx_sof ? '0 : pos_q;
  assign last   = take && (cur == POS_W'(ADDR_BYTES - 1));
  assign freeze = first || (pos_q != '0);

  always_comb begin
    sta_b = '0;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (cur == POS_W'(k)) sta_b = act_sta[8*k +: 8];
  end

  assign uc_n  = (first ? 1'b1 : uc_q) & (rx_data == sta_b);
  assign bc_n  = (first ? 1'b1 : bc_q) & (rx_data == 8'hFF);
  assign grp_n = first ? rx_data[0] : grp_q;
  assign hit   = act_hash[hash_idx];

  always_comb begin
    if (act_mode[MB_ALL])  acc_n = 1'b1;
    else if (bc_n)         acc_n = act_mode[MB_BC];
    else if (grp_n)        acc_n = act_mode[MB_MC] & hit;
    else                   acc_n = uc_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q      <= '0;
      uc_q       <= 1'b0;
      bc_q       <= 1'b0;
      grp_q      <= 1'b0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_group  <= 1'b0;
    end else begin
      dec_valid  <= last;
      dec_accept <= last & acc_n;
      dec_group  <= last & grp_n;
      if (take) begin
        pos_q <= last ? '0 : cur + 1'b1;
        uc_q  <= uc_n;
        bc_q  <= bc_n;
        grp_q <= grp_n;
      end
    end
  end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BYTES = 8,
  parameter int CFG_AW     = 4,
  parameter int MODE_ADDR  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic [7:0]        rx_data,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic              dec_group
);
  localparam int IDX_W = $clog2(HASH_BYTES * 8);

  logic [ADDR_BYTES*8-1:0] act_sta;
  logic [HASH_BYTES*8-1:0] act_hash;
  logic [2:0]              act_mode;
  logic [IDX_W-1:0]        hash_idx;
  logic                    take, first, freeze;

  filt_cfg #(.ADDR_BYTES(ADDR_BYTES), .HASH_BYTES(HASH_BYTES),
             .CFG_AW(CFG_AW), .MODE_ADDR(MODE_ADDR)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .freeze(freeze), .act_sta(act_sta),
    .act_hash(act_hash), .act_mode(act_mode));

  filt_crc #(.IDX_W(IDX_W)) u_crc (
    .clk(clk), .rst(rst), .take(take), .first(first),
    .data(rx_data), .hash_idx(hash_idx));

  filt_match #(.ADDR_BYTES(ADDR_BYTES), .HASH_BYTES(HASH_BYTES)) u_match (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_data(rx_data), .act_sta(act_sta), .act_hash(act_hash),
    .act_mode(act_mode), .hash_idx(hash_idx), .take(take), .first(first),
    .freeze(freeze), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_group(dec_group));
endmodule

// File: rtl/filt_chk.sv
module filt_chk #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BYTES = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    rx_valid,
  input logic                    rx_sof,
  input logic [7:0]              rx_data,
  input logic                    dec_valid,
  input logic                    dec_accept,
  input logic                    dec_group,
  input logic                    freeze,
  input logic [ADDR_BYTES*8-1:0] act_sta,
  input logic [HASH_BYTES*8-1:0] act_hash,
  input logic [2:0]              act_mode
);
  localparam int CW = $clog2(ADDR_BYTES + 1);
  logic [CW-1:0] cnt;
  logic          all_ff;
  logic          tk;

  assign tk = rx_valid && (rx_sof || (cnt != '0 && cnt < CW'(ADDR_BYTES)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      all_ff <= 1'b0;
    end else begin
      if (rx_valid && rx_sof)   cnt <= CW'(1);
      else if (tk)              cnt <= cnt + 1'b1;
      else if (cnt == CW'(ADDR_BYTES)) cnt <= '0;
      if (tk) all_ff <= (rx_sof ? 1'b1 : all_ff) & (rx_data == 8'hFF);
    end
  end

  // R6: one pulse per completed address
  assert_pulse_timing_R6: assert property (@(posedge clk) disable iff (rst)
    dec_valid == (cnt == CW'(ADDR_BYTES)));

  // R1: promiscuous mode always accepts
  assert_accept_all_R1: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && $past(act_mode[2])) |-> dec_accept);

  // R2: broadcast with its enable clear (and no promiscuous) is dropped
  assert_bcast_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && all_ff && !$past(act_mode[0]) && !$past(act_mode[2])) |-> !dec_accept);

  // R7: no verdict flags outside the pulse
  assert_quiet_reject_R7: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (!dec_accept && !dec_group));

  // R8: filtering copy holds during an address
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    freeze |=> ($stable(act_sta) && $stable(act_hash) && $stable(act_mode)));
endmodule

bind dest_addr_filter filt_chk #(.ADDR_BYTES(ADDR_BYTES), .HASH_BYTES(HASH_BYTES)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_group(dec_group),
  .freeze(freeze), .act_sta(act_sta), .act_hash(act_hash), .act_mode(act_mode));

// File: tb/sim_dest_addr_filter.sv
`timescale 1ns/1ps
module sim_dest_addr_filter;
  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_we;
  logic [3:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       rx_valid, rx_sof;
  logic [7:0] rx_data;
  logic       dec_valid, dec_accept, dec_group;

  int n_chk = 0;
  int n_bad = 0;
  int pulses;
  logic got_acc, got_grp;

  always #5 clk = ~clk;

  dest_addr_filter u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_data(rx_data), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_group(dec_group));

  localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
  localparam logic [47:0] MC1 = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] BC  = 48'hFF_FF_FF_FF_FF_FF;

  // {dest, mode, hash fill (0 none,1 only hit bit,2 all but hit bit), accept, group}
  localparam logic [59:0] VEC [0:13] = '{
    {STA,                 8'h00, 2'd0, 1'b1, 1'b0},  // R5 match
    {48'h02_11_22_33_44_56, 8'h00, 2'd0, 1'b0, 1'b0},  // R5 last byte differs
    {48'h06_11_22_33_44_55, 8'h00, 2'd0, 1'b0, 1'b0},  // R5 first byte differs
    {48'h06_11_22_33_44_55, 8'h10, 2'd0, 1'b1, 1'b0},  // R1
    {BC,                  8'h04, 2'd0, 1'b1, 1'b1},  // R2 enabled
    {BC,                  8'h08, 2'd1, 1'b0, 1'b1},  // R2 priority over multicast
    {BC,                  8'h00, 2'd0, 1'b0, 1'b1},  // R2 disabled
    {MC1,                 8'h08, 2'd1, 1'b1, 1'b1},  // R3/R4 hit
    {MC1,                 8'h08, 2'd0, 1'b0, 1'b1},  // R3 no hit
    {MC1,                 8'h08, 2'd2, 1'b0, 1'b1},  // R4 index precision
    {MC1,                 8'h04, 2'd1, 1'b0, 1'b1},  // R3 needs bit 3
    {MC1,                 8'h10, 2'd0, 1'b1, 1'b1},  // R1 multicast
    {48'h33_33_00_00_00_01, 8'h0C, 2'd1, 1'b1, 1'b1},  // R3/R4 second address
    {STA,                 8'h10, 2'd0, 1'b1, 1'b0}   // R1 with match
  };

  function automatic logic [5:0] ref_idx(input logic [47:0] d);
    logic [31:0] c;
    logic [7:0]  b;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      b = d[47 - 8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        fb = c[31] ^ b[j];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    return c[31:26];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic sample();
    if (dec_valid) begin
      pulses++;
      got_acc = dec_accept;
      got_grp = dec_group;
    end
  endtask

  // sends nb bytes (dest then filler); optional register write at byte wr_at
  task automatic send(input logic [47:0] d, input int nb, input int wr_at,
                      input logic [3:0] wa, input logic [7:0] wd);
    pulses = 0; got_acc = 1'b0; got_grp = 1'b0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      sample();
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_data  = (i < 6) ? d[47 - 8*i -: 8] : 8'hA5;
      cfg_we   = (i == wr_at);
      cfg_addr = wa;
      cfg_wdata = wd;
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      sample();
      rx_valid = 1'b0; rx_sof = 1'b0; cfg_we = 1'b0;
    end
  endtask

  task automatic set_station(input logic [47:0] s);
    for (int k = 0; k < 6; k++) wr(4'(k), s[47 - 8*k -: 8]);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 valid", 32'(dec_valid), 0);
    check("R9 accept", 32'(dec_accept), 0);
    check("R9 group", 32'(dec_group), 0);

    // R9: zeroed station matches an all-zero unicast
    send(48'h0, 6, -1, 4'd0, 8'd0);
    check("R9 zero station pulses", 32'(pulses), 1);
    check("R9 zero station accept", 32'(got_acc), 1);

    set_station(STA);

    foreach (VEC[v]) begin
      logic [47:0] d;
      logic [5:0]  ix;
      logic [7:0]  hv;
      d  = VEC[v][59:12];
      ix = ref_idx(d);
      for (int b = 0; b < 8; b++) begin
        case (VEC[v][3:2])
          2'd1:    hv = (b == int'(ix[5:3])) ? (8'h1 << ix[2:0]) : 8'h00;
          2'd2:    hv = (b == int'(ix[5:3])) ? ~(8'h1 << ix[2:0]) : 8'hFF;
          default: hv = 8'h00;
        endcase
        wr(4'(6 + b), hv);
      end
      wr(4'd15, VEC[v][11:4]);
      send(d, 6, -1, 4'd0, 8'd0);
      check($sformatf("R6 vec%0d pulses", v), 32'(pulses), 1);
      check($sformatf("R1/R2/R3/R5 vec%0d accept", v), 32'(got_acc), 32'(VEC[v][1]));
      check($sformatf("R6 vec%0d group", v), 32'(got_grp), 32'(VEC[v][0]));
    end

    wr(4'd15, 8'h00);
    // R8: write in the first-byte cycle is deferred one frame
    send(STA, 6, 0, 4'd5, 8'h66);
    check("R8 same-cycle write old value", 32'(got_acc), 1);
    send(STA, 6, -1, 4'd0, 8'd0);
    check("R8 write applied next frame", 32'(got_acc), 0);
    // R8: write during the address is deferred
    send(STA, 6, 3, 4'd5, 8'h55);
    check("R8 mid-address write deferred", 32'(got_acc), 0);
    send(STA, 6, -1, 4'd0, 8'd0);
    check("R8 mid-address write applied", 32'(got_acc), 1);

    // R6: bytes past the sixth are ignored
    send(STA, 14, -1, 4'd0, 8'd0);
    check("R6 long frame single pulse", 32'(pulses), 1);
    check("R6 long frame accept", 32'(got_acc), 1);

    // R6: early start-of-frame restarts the address
    send(BC, 3, -1, 4'd0, 8'd0);
    check("R6 truncated address no pulse", 32'(pulses), 0);
    send(STA, 6, -1, 4'd0, 8'd0);
    check("R6 restart pulse", 32'(pulses), 1);
    check("R6 restart accept", 32'(got_acc), 1);
    check("R7 restart group low", 32'(got_grp), 0);

    // R7: rejected unicast gives only a low-accept pulse
    send(48'h02_11_22_33_44_00, 6, -1, 4'd0, 8'd0);
    check("R7 reject pulse", 32'(pulses), 1);
    check("R7 reject accept low", 32'(got_acc), 0);
    check("R7 idle accept low", 32'(dec_accept), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule